// File: doc/BRIEF.md
# ROM Entry List Walker

This block walks a chain of variable-length records. The chain sits in a byte-wide ROM directly after a fixed 22-byte header. After a start strobe, the walker fetches bytes through a read port with one cycle of latency. It follows each record's length byte to reach the next record. For every record it emits one pulse of decoded fields: the slot index, whether it is a port record, the disabled flag, the link number, and the optional dual-link partner.

Each walk ends with exactly one indication. A done pulse means the chain ended cleanly at the ROM size. An error pulse means the chain ran past the end of the ROM. The ROM size is given as an 11-bit byte count. Looking up the real port type, and acting on the decoded records, are left to the consumer.

Top module: `rom_entry_walker`

## Requirements
- R1: During and after a synchronous active-high reset, `busy`, `done`, `err` and `ent_valid` are low.
- R2: An accepted `start` sets the walk position to byte 22. While the position is below `rom_size`, the walk continues. When the position is at or above `rom_size`, one `done` pulse ends the walk. A `rom_size` of 22 or less therefore gives `done` with no records.
- R3: A record's byte 0 is its length. In byte 1, bits 5:0 are the slot index (`ent_index`), bit 6 is the disabled flag (`ent_disabled`) and bit 7 is the kind (1 = port, 0 = generic, reported as `ent_is_port`).
- R4: If the position plus 1 equals `rom_size`, the walk ends with one `err` pulse, and that record is not emitted.
- R5: If the length byte is 0, or the position plus the length exceeds `rom_size`, the walk ends with one `err` pulse, and that record is not emitted.
- R6: Each record that passes the checks gives exactly one `ent_valid` pulse. The position then advances by the length, and records come out in ROM order.
- R7: Generic records and disabled port records are reported with `ent_link`, `ent_dual_valid`, `ent_dual_port` and `ent_len_err` all zero.
- R8: A port record that is not disabled and whose length is not 8 is reported with `ent_len_err` = 1 and the link and partner fields zero. The walk then continues.
- R9: A port record that is not disabled and has length 8 reports `ent_link` = byte 2 bit 4, `ent_dual_valid` = byte 2 bit 7, and `ent_dual_port` = byte 3 bits 5:0.
- R10: Each accepted `start` produces exactly one `done` or `err` pulse, never both together. A `start` raised while `busy` is high is ignored.
- R11: Positions use 11 bits and the end-of-record sum uses 12, so walks up to a `rom_size` of 2047 are handled without wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| rom_size | input | 11 | Total ROM size in bytes |
| rd_addr | output | 11 | ROM byte address, registered |
| rd_data | input | 8 | ROM byte, valid one cycle after `rd_addr` |
| busy | output | 1 | Walk in progress |
| ent_valid | output | 1 | One-cycle pulse: record fields valid |
| ent_index | output | 6 | Slot index of record |
| ent_is_port | output | 1 | Record kind is port |
| ent_disabled | output | 1 | Port disabled flag |
| ent_link | output | 1 | Link number of port |
| ent_dual_valid | output | 1 | Dual-link partner present |
| ent_dual_port | output | 6 | Dual-link partner slot |
| ent_len_err | output | 1 | Enabled port record not 8 bytes long |
| done | output | 1 | Walk ended cleanly (pulse) |
| err | output | 1 | Walk aborted on overrun (pulse) |

## Verification
The assertions assume that `rom_size` is held steady for the whole walk. They also assume that `rd_data` returns the byte at the address presented one cycle earlier. The bench keeps to both conditions: it changes the size only between walks, while the walker is idle, and it models the ROM as a registered array. `start` is raised again mid-walk only when `busy` is seen high, so that the ignore rule is tested. Record lengths are drawn mostly from 1 to 8, with rare zeros. Sizes are picked either on record boundaries or at arbitrary bytes, so that clean ends and all three abort cases all occur.

// File: rtl/rew_pkg.sv
package rew_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_A0,
    ST_A1,
    ST_HDR,
    ST_B2,
    ST_B3
  } walk_st_t;

  typedef struct packed {
    logic [5:0] index;
    logic       is_port;
    logic       disabled;
    logic       link;
    logic       dual_valid;
    logic [5:0] dual_port;
    logic       len_err;
  } rec_t;

endpackage

// File: rtl/rew_bound_chk.sv
module rew_bound_chk #(
  parameter int AW = 11
) (
  input  logic [AW-1:0] pos,
  input  logic [AW-1:0] size,
  input  logic [7:0]    len,
  output logic          at_end,
  output logic          tail_one,
  output logic          len_bad,
  output logic [AW-1:0] next_pos
);
  localparam int SW = AW + 1;

  logic [SW-1:0] pos_ext;
  logic [SW-1:0] size_ext;
  logic [SW-1:0] end_sum;

  always_comb begin
    pos_ext  = {1'b0, pos};
    size_ext = {1'b0, size};
    end_sum  = pos_ext + SW'(len);
    at_end   = pos_ext >= size_ext;
    tail_one = (pos_ext + SW'(1)) == size_ext;
    len_bad  = (len == 8'd0) || (end_sum > size_ext);
    next_pos = end_sum[AW-1:0];
  end
endmodule

// File: rtl/rew_rec_decode.sv
module rew_rec_decode
  import rew_pkg::*;
#(
  parameter int PORT_LEN = 8
) (
  input  logic [7:0] hdr,
  input  logic [7:0] len,
  input  logic       b2_link,
  input  logic       b2_dual,
  input  logic [5:0] b3_port,
  output rec_t       rec,
  output logic       need_body
);
  logic live_port;

  always_comb begin
    live_port      = hdr[7] & ~hdr[6];
    need_body      = live_port & (len == 8'(PORT_LEN));
    rec.index      = hdr[5:0];
    rec.is_port    = hdr[7];
    rec.disabled   = hdr[6];
    rec.len_err    = live_port & (len != 8'(PORT_LEN));
    rec.link       = need_body & b2_link;
    rec.dual_valid = need_body & b2_dual;
    rec.dual_port  = need_body ? b3_port : 6'd0;
  end
endmodule

// File: rtl/rom_entry_walker.sv
module rom_entry_walker
  import rew_pkg::*;
#(
  parameter int AW        = 11,
  parameter int HDR_BYTES = 22,
  parameter int PORT_LEN  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] rom_size,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          ent_valid,
  output logic [5:0]    ent_index,
  output logic          ent_is_port,
  output logic          ent_disabled,
  output logic          ent_link,
  output logic          ent_dual_valid,
  output logic [5:0]    ent_dual_port,
  output logic          ent_len_err,
  output logic          done,
  output logic          err
);
  localparam logic [AW-1:0] START_POS = AW'(HDR_BYTES);

  walk_st_t      state;
  logic [AW-1:0] pos;
  logic [7:0]    len_q;
  logic [7:0]    hdr_q;
  logic          b2_link_q;
  logic          b2_dual_q;
  rec_t          rec_q;

  logic          at_end, tail_one, len_bad;
  logic [AW-1:0] next_pos;
  logic [7:0]    hdr_sel;
  rec_t          rec_d;
  logic          need_body;

  rew_bound_chk #(.AW(AW)) u_bound (
    .pos      (pos),
    .size     (rom_size),
    .len      (len_q),
    .at_end   (at_end),
    .tail_one (tail_one),
    .len_bad  (len_bad),
    .next_pos (next_pos)
  );

  assign hdr_sel = (state == ST_HDR) ? rd_data : hdr_q;

  rew_rec_decode #(.PORT_LEN(PORT_LEN)) u_dec (
    .hdr       (hdr_sel),
    .len       (len_q),
    .b2_link   (b2_link_q),
    .b2_dual   (b2_dual_q),
    .b3_port   (rd_data[5:0]),
    .rec       (rec_d),
    .need_body (need_body)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pos       <= '0;
      len_q     <= '0;
      hdr_q     <= '0;
      b2_link_q <= 1'b0;
      b2_dual_q <= 1'b0;
      rd_addr   <= '0;
      rec_q     <= '0;
      ent_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      ent_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            pos   <= START_POS;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (at_end) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (tail_one) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            rd_addr <= pos;
            state   <= ST_A0;
          end
        end
        ST_A0: begin
          rd_addr <= pos + AW'(1);
          state   <= ST_A1;
        end
        ST_A1: begin
          len_q   <= rd_data;
          rd_addr <= pos + AW'(2);
          state   <= ST_HDR;
        end
        ST_HDR: begin
          hdr_q <= rd_data;
          if (len_bad) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (need_body) begin
            rd_addr <= pos + AW'(3);
            state   <= ST_B2;
          end else begin
            rec_q     <= rec_d;
            ent_valid <= 1'b1;
            pos       <= next_pos;
            state     <= ST_CHECK;
          end
        end
        ST_B2: begin
          b2_link_q <= rd_data[4];
          b2_dual_q <= rd_data[7];
          state     <= ST_B3;
        end
        ST_B3: begin
          rec_q     <= rec_d;
          ent_valid <= 1'b1;
          pos       <= next_pos;
          state     <= ST_CHECK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy           = (state != ST_IDLE);
  assign ent_index      = rec_q.index;
  assign ent_is_port    = rec_q.is_port;
  assign ent_disabled   = rec_q.disabled;
  assign ent_link       = rec_q.link;
  assign ent_dual_valid = rec_q.dual_valid;
  assign ent_dual_port  = rec_q.dual_port;
  assign ent_len_err    = rec_q.len_err;

  // Outcome pulses are exclusive and close the walk (R10)
  p_single_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  p_outcome_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !busy);
  p_restart_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done || err));

  // Records only appear inside a walk, never with the outcome (R6, R5)
  p_rec_in_walk_r6: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> busy);
  p_no_rec_on_outcome_r5: assert property (@(posedge clk) disable iff (rst)
    !(ent_valid && (done || err)));

  // Generic or disabled records carry no port detail (R7)
  p_plain_rec_r7: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && (!ent_is_port || ent_disabled)) |->
      (!ent_link && !ent_dual_valid && !ent_len_err && ent_dual_port == 6'd0));

  // Length fault only on enabled port records, with no link detail (R8)
  p_len_err_port_r8: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_len_err) |->
      (ent_is_port && !ent_disabled && !ent_link && !ent_dual_valid));

endmodule

// File: tb/rom_entry_walker_tb.sv
module rom_entry_walker_tb;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] rom_size = '0;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          busy, ent_valid, ent_is_port, ent_disabled, ent_link;
  logic          ent_dual_valid, ent_len_err, done, err;
  logic [5:0]    ent_index, ent_dual_port;

  always #2 clk = ~clk;

  rom_entry_walker u_dut (
    .clk(clk), .rst(rst), .start(start), .rom_size(rom_size),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .ent_valid(ent_valid), .ent_index(ent_index), .ent_is_port(ent_is_port),
    .ent_disabled(ent_disabled), .ent_link(ent_link),
    .ent_dual_valid(ent_dual_valid), .ent_dual_port(ent_dual_port),
    .ent_len_err(ent_len_err), .done(done), .err(err)
  );

  logic [7:0] rom [0:2047];
  always @(posedge clk) rd_data <= rom[rd_addr];

  int n_chk = 0, n_bad = 0;
  int seed = 32'h1234_5678;
  int cyc = 0;

  // expected model outputs
  logic [16:0] exp_rec [0:511];
  int          exp_tag [0:511];
  int          e_n;
  int          e_reason;   // 0 clean end, 1 tail byte, 2 bad length
  int          got_n, outcomes, got_err;
  int          bounds [0:255];
  int          n_bounds;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h00ff_ffff;
  endfunction

  task automatic model(input int sz);
    int p = 22;
    e_n = 0;
    e_reason = 0;
    while (p < sz) begin
      int len; logic [7:0] b1, b2, b3; logic live;
      if (p + 1 == sz) begin e_reason = 1; return; end
      len = rom[p];
      if (len == 0 || p + len > sz) begin e_reason = 2; return; end
      b1 = rom[p+1]; b2 = rom[p+2]; b3 = rom[p+3];
      live = b1[7] && !b1[6];
      if (live && len == 8) begin
        exp_rec[e_n] = {1'b0, b3[5:0], b2[7], b2[4], b1[6], b1[7], b1[5:0]};
        exp_tag[e_n] = 9;
      end else if (live) begin
        exp_rec[e_n] = {1'b1, 6'd0, 1'b0, 1'b0, b1[6], b1[7], b1[5:0]};
        exp_tag[e_n] = 8;
      end else begin
        exp_rec[e_n] = {1'b0, 6'd0, 1'b0, 1'b0, b1[6], b1[7], b1[5:0]};
        exp_tag[e_n] = 7;
      end
      e_n++;
      p += len;
    end
  endtask

  // record monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (ent_valid) begin
        logic [16:0] act;
        act = {ent_len_err, ent_dual_port, ent_dual_valid, ent_link,
               ent_disabled, ent_is_port, ent_index};
        if (got_n >= e_n) check(1'b0, "R6 extra record", int'(act), 0);
        else begin
          check(act[5:0] == exp_rec[got_n][5:0], "R3 index", int'(act[5:0]),
                int'(exp_rec[got_n][5:0]));
          case (exp_tag[got_n])
            9:       check(act == exp_rec[got_n], "R9 port fields", int'(act), int'(exp_rec[got_n]));
            8:       check(act == exp_rec[got_n], "R8 length fault", int'(act), int'(exp_rec[got_n]));
            default: check(act == exp_rec[got_n], "R7 plain record", int'(act), int'(exp_rec[got_n]));
          endcase
        end
        got_n++;
      end
      if (done || err) begin
        outcomes++;
        got_err = err ? 1 : 0;
      end
    end
  end

  task automatic run_walk(input int sz, input bit restart);
    int wait_c = 0;
    rom_size = AW'(sz);
    model(sz);
    got_n = 0; outcomes = 0; got_err = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (restart) begin
      @(negedge clk);
      if (busy) begin
        start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
    end
    while (outcomes == 0 && wait_c < 6000) begin
      @(negedge clk);
      wait_c++;
    end
    repeat (4) @(negedge clk);
    check(wait_c < 6000, "R10 walk finished", wait_c, 0);
    check(outcomes == 1, "R10 one outcome", outcomes, 1);
    check(!busy, "R10 idle after outcome", int'(busy), 0);
    check(got_n == e_n, "R6 record count", got_n, e_n);
    case (e_reason)
      0:       check(got_err == 0, "R2 clean end", got_err, 0);
      1:       check(got_err == 1, "R4 tail byte abort", got_err, 1);
      default: check(got_err == 1, "R5 length abort", got_err, 1);
    endcase
  endtask

  task automatic gen_rom();
    int p = 22;
    for (int i = 0; i < 320; i++) rom[i] = 8'(rnd());
    n_bounds = 0;
    while (p < 230) begin
      int r = rnd() % 16;
      int len = (r < 7) ? 8 : (r == 15) ? 0 : r - 6;
      rom[p] = 8'(len);
      if (len == 0) break;
      p += len;
      bounds[n_bounds] = p;
      n_bounds++;
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin : main
    for (int i = 0; i < 2048; i++) rom[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !ent_valid, "R1 reset outputs",
          int'({busy, done, err, ent_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err && !ent_valid, "R1 after reset",
          int'({busy, done, err, ent_valid}), 0);

    // R2 small sizes: no records
    run_walk(0, 1'b0);
    run_walk(22, 1'b0);
    // R4 one byte past header
    run_walk(23, 1'b0);
    // R9 single well-formed port record
    rom[22] = 8'd8; rom[23] = 8'h85; rom[24] = 8'h90; rom[25] = 8'hC3;
    run_walk(30, 1'b0);
    // R5 zero-length record
    rom[22] = 8'd0;
    run_walk(40, 1'b0);

    // R11 long chain reaching near the 11-bit top
    for (int p = 22; p < 2047; p += 8) begin
      rom[p] = 8'd8; rom[p+1] = 8'(8'h80 | ((p >> 3) & 8'h3F));
    end
    run_walk(2047, 1'b0);
    run_walk(2046, 1'b1);

    // sweep of generated chains and sizes
    for (int t = 0; t < 400; t++) begin
      int sz;
      gen_rom();
      if ((t % 2 == 0) && n_bounds > 0) sz = bounds[rnd() % n_bounds];
      else sz = 22 + (rnd() % 200);
      run_walk(sz, t % 3 == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule